// File: doc/BRIEF.md
# Toggle-Triggered Falling-Edge Single-Port RAM

This block is a single-port synchronous memory placed next to a datapath whose registers and state machine run on the rising clock edge. The datapath does not hold an enable level to request an access. It inverts a request line in the one state that performs the load or store. The memory keeps its own copy of that line. An access is pending whenever the two copies disagree.

On the falling edge the memory serves the pending access. A store writes the word. A load captures the word in a read-data register. In the same edge the memory copies the request line into its own copy, which ends the request. The datapath therefore never drives a disable and needs no extra state. A store is complete half a cycle after it is issued. Load data is valid at the next rising edge, so the datapath reads it in the state that follows the issuing state.

Top module: `toggle_ram`

## Requirements
- R1: The memory performs an access only on a falling edge where the request line `req_tgl` differs from its internal copy. Holding `req_tgl` at either level, for any number of cycles, performs no access, whatever `wr_sel`, `addr` and `wdata` carry.
- R2: Each serviced access sets the internal copy equal to `req_tgl` on that falling edge. Provided the requester changes `req_tgl` only just after rising edges, the two values are equal at every rising edge.
- R3: An access with `wr_sel` = 1 writes `wdata` to location `addr` on the falling edge of the cycle in which the toggle was issued.
- R4: An access with `wr_sel` = 0 loads location `addr` into `rdata` on the falling edge of the issuing cycle. The value can be sampled at the next rising edge.
- R5: `rdata` changes only on a load or a reset. Stores and idle cycles leave it unchanged.
- R6: Toggling `req_tgl` in every cycle gives one access per falling edge, with no lost or repeated access.
- R7: Reset is synchronous and sampled on the falling edge. It clears the internal copy and `rdata` to zero and leaves the array contents unchanged.
- R8: When reset is high on a falling edge at which a request is pending, the request is dropped and the array is not written.
- R9: A load from an address issued in the cycle directly after a store to that address returns the newly stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The array acts on the falling edge. |
| rst | input | 1 | Synchronous reset, active high, sampled on the falling edge. |
| req_tgl | input | 1 | Request line. Each change of level requests one access. |
| wr_sel | input | 1 | Access kind: 1 is a store, 0 is a load. |
| addr | input | ADDR_W | Word address. |
| wdata | input | DATA_W | Word to store. |
| rdata | output | DATA_W | Last loaded word. |

## Verification
Two functions can fall on the same falling edge.

The first pair is reset and a pending request. The bench raises reset in the same cycle in which it flips the request line to ask for a store. After reset it reads that location and expects the old word, with `rdata` cleared in the meantime.

The second pair is a store followed at the very next edge by a load of the same word. The bench issues the two accesses back to back on one address. The load result is compared with the newly stored value, which the bench computes from its own address-based pattern.

// File: rtl/toggle_ram.sv
module toggle_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_tgl,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              own_en;
  logic              pend;

  assign pend = req_tgl != own_en;

  always_ff @(negedge clk) begin
    if (rst) begin
      own_en <= 1'b0;
      rdata  <= '0;
    end else if (pend) begin
      own_en <= req_tgl;
      if (!wr_sel) rdata <= mem[addr];
    end
  end

  always_ff @(negedge clk) begin
    if (!rst && pend && wr_sel) mem[addr] <= wdata;
  end

  a_r2_idle_at_rise: assert property (@(posedge clk) disable iff (rst)
    req_tgl == own_en);

  a_r2_self_clear: assert property (@(negedge clk) disable iff (rst)
    pend |=> own_en == $past(req_tgl));

  a_r3_store_lands: assert property (@(negedge clk) disable iff (rst)
    (pend && wr_sel) |=> mem[$past(addr)] == $past(wdata));

  a_r5_rdata_holds: assert property (@(negedge clk) disable iff (rst)
    !(pend && !wr_sel) |=> $stable(rdata));

  a_r7_reset_clears: assert property (@(negedge clk)
    rst |=> (own_en == 1'b0 && rdata == '0));
endmodule

// File: tb/sim_toggle_ram.sv
`timescale 1ns/1ps
module sim_toggle_ram;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_tgl;
  logic          wr_sel;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  toggle_ram #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .req_tgl(req_tgl), .wr_sel(wr_sel),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [DW-1:0] pat_a(int a);
    return DW'(a * 37 + 5);
  endfunction

  function automatic logic [DW-1:0] pat_b(int a);
    return DW'(a * 11 + 200);
  endfunction

  task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic issue(logic w, int a, logic [DW-1:0] d);
    req_tgl = ~req_tgl;
    wr_sel  = w;
    addr    = AW'(a);
    wdata   = d;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst = 1'b1; req_tgl = 1'b0; wr_sel = 1'b0; addr = '0; wdata = '0;
    repeat (3) step();
    chk("R7 reset value", rdata, '0);
    rst = 1'b0;

    // R3 R6: back-to-back stores over the whole array
    for (int a = 0; a < N; a++) begin
      step();
      issue(1'b1, a, pat_a(a));
    end
    // R4 R6: back-to-back loads, each result sampled one rising edge later
    step();
    issue(1'b0, 0, '0);
    for (int a = 1; a <= N; a++) begin
      step();
      chk("R4 R6 load sweep", rdata, pat_a(a - 1));
      if (a < N) issue(1'b0, a, '0);
    end

    // R5: a store leaves rdata unchanged
    issue(1'b1, 3, pat_b(3));
    // R1 R5: level held, inputs moving, no access
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R5 hold after store/idle", rdata, pat_a(N - 1));
      wr_sel = 1'b1; addr = AW'(5); wdata = 8'hEE;
    end
    step();
    issue(1'b0, 5, '0);
    step();
    chk("R1 held level caused no store", rdata, pat_a(5));

    // R9: store then load of the same address in consecutive cycles
    issue(1'b1, 7, pat_b(7));
    step();
    issue(1'b0, 7, '0);
    step();
    chk("R9 load right after store", rdata, pat_b(7));
    issue(1'b0, 3, '0);
    step();
    chk("R3 earlier store visible", rdata, pat_b(3));

    // R8: reset coincides with a pending store; line left at 0 after reset
    if (req_tgl == 1'b0) begin
      issue(1'b0, 0, '0);
      step();
    end
    rst = 1'b1;
    issue(1'b1, 9, 8'h55);
    step();
    step();
    chk("R7 reset clears rdata", rdata, '0);
    rst = 1'b0;
    step();
    chk("R7 rdata stays zero after reset", rdata, '0);
    issue(1'b0, 9, '0);
    step();
    chk("R8 dropped store during reset", rdata, pat_a(9));
    issue(1'b0, 12, '0);
    step();
    chk("R7 memory kept through reset", rdata, pat_a(12));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule